// File: doc/BRIEF.md
# Parallel 7/8 Polyphase Rate Converter

This block converts a wide sample stream to seven eighths of its rate. On every valid beat it accepts eight samples that follow one another in time, and it returns seven filtered samples. The arithmetic is equivalent to three steps. The stream is zero-stuffed by seven and filtered with a 56-tap prototype. Only every eighth result of that filter is kept. The block does not run those steps in series: it unrolls one whole polyphase cycle, so each of the seven output lanes has its own fixed-coefficient sub-filter of eight taps. Input and output therefore share one clock, one beat in and one beat out, and no commutator is needed.

Some taps of the current beat reach back before the newest eight samples. The block keeps the seven youngest samples of the last accepted beat for them. Products are registered in one stage. The next stage sums them at full precision, rounds, saturates to 16 bits and registers the result. Repacking the seven lanes into eight, clock crossing and coefficient design happen outside this block.

Top module: `rs78_resampler_par`

## Requirements
- R1: Input lane i (in_data bits 16i+15..16i) carries sample 8b+7-i of beat b, so lane 0 is the youngest. Output lane k (out_data bits 16k+15..16k) carries output sample 7b+k.
- R2: Output sample q equals the sum over input samples n of h[8q-7n]·x[n], taken over the terms with 0 ≤ 8q-7n ≤ 55. Samples are 16-bit two's complement, and samples before reset count as zero.
- R3: The coefficients are fixed: h[j] = 1000·t(j) - 6000, with t(j) = j+1 for j < 28 and t(j) = 56-j otherwise.
- R4: Taps that reach before the current beat use the last beat accepted with in_valid high. A cycle with in_valid low changes neither the history nor any later output.
- R5: out_valid rises exactly two clocks after each accepted beat, and each accepted beat yields exactly seven outputs. No valid output appears without an accepted beat.
- R6: Rounding adds 2^14 to the full-precision sum and then shifts it arithmetically right by 15, which rounds halves upward.
- R7: A rounded result above 32767 is replaced by 32767, and one below -32768 by -32768.
- R8: Synchronous active-high reset clears the history, out_valid and out_data. The first outputs after reset are computed as if all earlier samples were zero.
- R9: out_data keeps its last value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the input beat |
| in_data | input | 128 | Eight input samples, lane 0 the youngest |
| out_valid | output | 1 | Output beat valid, two clocks after an accepted beat |
| out_data | output | 112 | Seven output samples, lane 0 the oldest |

## Verification
Single impulses placed at each of the eight input lanes, followed by zero beats, show each lane's coefficient and tap order and how a tap crosses into the next beat. A second impulse amplitude with the opposite sign makes a swapped lane or a wrong sign visible. Ramps then exercise every tap at once. Gaps carrying nonzero data with in_valid low show whether the history is protected. Full-scale constant and alternating beats drive both saturation limits. Long random runs mix small values, where rounding decides the result, with full-range values. A reset in the middle of a stream must bring back zero-padded history.

// File: rtl/rs78_pkg.sv
package rs78_pkg;

  localparam int SMP_W    = 16;
  localparam int COEF_W   = 16;
  localparam int IN_LANES = 8;
  localparam int OUT_LANES = 7;
  localparam int TAPS_PH  = 8;
  localparam int FRAC_W   = 15;

  localparam int COEF_STEP = 1000;
  localparam int COEF_BIAS = 6000;

  // Triangular prototype with a negative offset, indexed 0..total-1.
  function automatic int coef_at(input int j, input int total);
    int half;
    int tri_v;
    half  = total / 2;
    tri_v = (j < half) ? (j + 1) : (total - j);
    return COEF_STEP * tri_v - COEF_BIAS;
  endfunction

endpackage

// File: rtl/rs78_history.sv
module rs78_history #(
  parameter int SMP_W    = 16,
  parameter int IN_LANES = 8,
  parameter int KEEP     = 7,
  parameter int SPAN     = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [IN_LANES*SMP_W-1:0]  in_data,
  output logic [KEEP*SMP_W-1:0]      hist_q,
  output logic [SPAN*SMP_W-1:0]      window
);

  localparam int CAT = KEEP + IN_LANES;

  // Time-ordered concatenation: slot 0 is the oldest retained sample.
  logic [CAT*SMP_W-1:0] cat;

  always_comb begin
    for (int j = 0; j < CAT; j++) begin
      if (j < KEEP)
        cat[j*SMP_W +: SMP_W] = hist_q[j*SMP_W +: SMP_W];
      else
        cat[j*SMP_W +: SMP_W] = in_data[(IN_LANES-1-(j-KEEP))*SMP_W +: SMP_W];
    end
  end

  assign window = cat[0 +: SPAN*SMP_W];

  always_ff @(posedge clk) begin
    if (rst)
      hist_q <= '0;
    else if (in_valid)
      hist_q <= cat[(CAT-KEEP)*SMP_W +: KEEP*SMP_W];
  end

endmodule

// File: rtl/rs78_round_sat.sv
module rs78_round_sat #(
  parameter int ACC_W  = 35,
  parameter int SMP_W  = 16,
  parameter int FRAC_W = 15
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic        [SMP_W-1:0] y
);

  localparam int SUM_W = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(2**(FRAC_W-1));
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((2**(SMP_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV - 1;

  logic signed [SUM_W-1:0] biased;
  logic signed [SUM_W-1:0] shifted;

  always_comb begin
    biased  = {acc[ACC_W-1], acc} + HALF;
    shifted = biased >>> FRAC_W;
    if (shifted > MAXV)
      y = SMP_W'(MAXV);
    else if (shifted < MINV)
      y = SMP_W'(MINV);
    else
      y = SMP_W'(shifted);
  end

endmodule

// File: rtl/rs78_phase_mac.sv
module rs78_phase_mac #(
  parameter int SMP_W     = 16,
  parameter int COEF_W    = 16,
  parameter int TAPS_PH   = 8,
  parameter int OUT_LANES = 7,
  parameter int PHASE     = 0,
  parameter int FRAC_W    = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [TAPS_PH*SMP_W-1:0] taps,
  output logic [SMP_W-1:0]         y_q
);

  localparam int TOTAL  = TAPS_PH * OUT_LANES;
  localparam int PROD_W = SMP_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS_PH);

  logic signed [PROD_W-1:0] prod_q [TAPS_PH];
  logic signed [ACC_W-1:0]  acc;
  logic        [SMP_W-1:0]  y_rs;

  // taps slot TAPS_PH-1 is the newest sample; tap t reaches t samples back.
  for (genvar t = 0; t < TAPS_PH; t++) begin : g_tap
    localparam logic signed [COEF_W-1:0] CF =
      COEF_W'(rs78_pkg::coef_at(PHASE + OUT_LANES*t, TOTAL));
    logic signed [SMP_W-1:0] smp;
    assign smp = $signed(taps[(TAPS_PH-1-t)*SMP_W +: SMP_W]);
    always_ff @(posedge clk) begin
      prod_q[t] <= smp * CF;
    end
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS_PH; t++)
      acc = acc + ACC_W'(prod_q[t]);
  end

  rs78_round_sat #(
    .ACC_W (ACC_W),
    .SMP_W (SMP_W),
    .FRAC_W(FRAC_W)
  ) round_i (
    .acc(acc),
    .y  (y_rs)
  );

  always_ff @(posedge clk) begin
    if (rst)
      y_q <= '0;
    else if (en)
      y_q <= y_rs;
  end

endmodule

// File: rtl/rs78_resampler_par.sv
module rs78_resampler_par #(
  parameter int SMP_W     = rs78_pkg::SMP_W,
  parameter int COEF_W    = rs78_pkg::COEF_W,
  parameter int IN_LANES  = rs78_pkg::IN_LANES,
  parameter int OUT_LANES = rs78_pkg::OUT_LANES,
  parameter int TAPS_PH   = rs78_pkg::TAPS_PH,
  parameter int FRAC_W    = rs78_pkg::FRAC_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [IN_LANES*SMP_W-1:0]   in_data,
  output logic                        out_valid,
  output logic [OUT_LANES*SMP_W-1:0]  out_data
);

  // Clocks from an accepted beat to out_valid: product stage, then sum stage.
  localparam int LATENCY    = 2;
  localparam int KEEP       = TAPS_PH - 1;
  localparam int MAX_NEWEST = (IN_LANES * (OUT_LANES - 1)) / OUT_LANES;
  localparam int SPAN       = KEEP + MAX_NEWEST + 1;

  logic [KEEP*SMP_W-1:0] hist_flat;
  logic [SPAN*SMP_W-1:0] window;
  logic [LATENCY-1:0]    vld_pipe;

  rs78_history #(
    .SMP_W   (SMP_W),
    .IN_LANES(IN_LANES),
    .KEEP    (KEEP),
    .SPAN    (SPAN)
  ) hist_i (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_data (in_data),
    .hist_q  (hist_flat),
    .window  (window)
  );

  // Output k keeps interpolated index 8k of the cycle: phase (IN*k) mod OUT,
  // newest input at beat offset floor(IN*k/OUT).
  for (genvar k = 0; k < OUT_LANES; k++) begin : g_lane
    localparam int NEWEST = (IN_LANES * k) / OUT_LANES;
    localparam int PHASE  = (IN_LANES * k) % OUT_LANES;
    localparam int LOW    = KEEP + NEWEST - (TAPS_PH - 1);
    rs78_phase_mac #(
      .SMP_W    (SMP_W),
      .COEF_W   (COEF_W),
      .TAPS_PH  (TAPS_PH),
      .OUT_LANES(OUT_LANES),
      .PHASE    (PHASE),
      .FRAC_W   (FRAC_W)
    ) mac_i (
      .clk (clk),
      .rst (rst),
      .en  (vld_pipe[0]),
      .taps(window[LOW*SMP_W +: TAPS_PH*SMP_W]),
      .y_q (out_data[k*SMP_W +: SMP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      vld_pipe <= '0;
    else
      vld_pipe <= {vld_pipe[LATENCY-2:0], in_valid};
  end

  assign out_valid = vld_pipe[LATENCY-1];

endmodule

// File: rtl/rs78_checker.sv
module rs78_checker #(
  parameter int OUT_W  = 112,
  parameter int HIST_W = 112
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_data,
  input logic [HIST_W-1:0] hist
);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)
      since_rst <= '0;
    else if (since_rst != 2'd3)
      since_rst <= since_rst + 2'd1;
  end

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> $stable(out_data));

  assert_history_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(in_valid)) |-> $stable(hist));

endmodule

bind rs78_resampler_par rs78_checker #(
  .OUT_W (OUT_LANES*SMP_W),
  .HIST_W((TAPS_PH-1)*SMP_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_data (out_data),
  .hist     (hist_flat)
);

// File: tb/rs78_resampler_par_tb_top.sv
module rs78_resampler_par_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [111:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs78_resampler_par dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string tag = "R8";
  int    xs[$];
  bit    p1v = 0, p2v = 0;
  int    p1d[7], p2d[7], last_d[7];
  int    z[8];

  function automatic int ref_coef(int j);
    int tv;
    tv = (j < 28) ? (j + 1) : (56 - j);
    return 1000 * tv - 6000;
  endfunction

  function automatic int rnd_sat(longint v);
    longint r;
    r = (v + 64'sd16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic int lane_out(int k);
    return int'($signed(out_data[k*16 +: 16]));
  endfunction

  task automatic check_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Serial reference: zero-stuff by 7, 56-tap FIR, keep every 8th.
  task automatic ref_beat(input int s[8]);
    int b;
    b = xs.size() / 8;
    for (int i = 0; i < 8; i++) xs.push_back(s[i]);
    for (int k = 0; k < 7; k++) begin
      longint acc;
      int m;
      acc = 0;
      m = 8 * (7 * b + k);
      for (int n = 0; n < xs.size(); n++) begin
        int j;
        j = m - 7 * n;
        if (j >= 0 && j < 56) acc += longint'(ref_coef(j)) * longint'(xs[n]);
      end
      p1d[k] = rnd_sat(acc);
    end
  endtask

  // s[0] is the oldest sample of the beat.
  task automatic step(input bit r, input bit v, input int s[8]);
    @(negedge clk);
    check_int("R5", "out_valid", int'(out_valid), int'(p2v));
    for (int k = 0; k < 7; k++) begin
      if (p2v)
        check_int(tag, $sformatf("lane %0d", k), lane_out(k), p2d[k]);
      else
        check_int("R9", $sformatf("held lane %0d", k), lane_out(k), last_d[k]);
    end
    if (p2v) last_d = p2d;
    p2v = p1v;
    p2d = p1d;
    rst = r;
    in_valid = v && !r;
    for (int i = 0; i < 8; i++) in_data[(7-i)*16 +: 16] = 16'(s[i]);
    if (r) begin
      xs.delete();
      p1v = 0;
      p2v = 0;
      for (int k = 0; k < 7; k++) last_d[k] = 0;
    end else if (v) begin
      ref_beat(s);
      p1v = 1;
    end else begin
      p1v = 0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s[8];
    for (int i = 0; i < 8; i++) z[i] = 0;
    for (int k = 0; k < 7; k++) begin last_d[k] = 0; p1d[k] = 0; p2d[k] = 0; end

    repeat (3) step(1, 0, z);
    check_int("R8", "out_valid after reset", int'(out_valid), 0);
    check_int("R8", "out_data after reset", int'(out_data == '0), 1);

    tag = "R1";
    for (int p = 0; p < 8; p++) begin
      s = z; s[p] = 8192;
      step(0, 1, s); step(0, 1, z); step(0, 1, z);
    end
    tag = "R3";
    for (int p = 0; p < 8; p++) begin
      s = z; s[p] = -20000;
      step(0, 1, s); step(0, 1, z);
    end

    tag = "R2";
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 8; i++) s[i] = (b * 8 + i) * 300 - 7000;
      step(0, 1, s);
    end

    tag = "R4";
    for (int i = 0; i < 8; i++) s[i] = 1000 * i - 3500;
    step(0, 1, s);
    for (int i = 0; i < 8; i++) s[i] = 30000;
    repeat (3) step(0, 0, s);
    for (int i = 0; i < 8; i++) s[i] = -900 * i;
    step(0, 1, s);
    step(0, 0, s);

    tag = "R7";
    for (int i = 0; i < 8; i++) s[i] = 32767;
    repeat (3) step(0, 1, s);
    for (int i = 0; i < 8; i++) s[i] = -32768;
    repeat (3) step(0, 1, s);
    for (int i = 0; i < 8; i++) s[i] = (i % 2 == 0) ? 32767 : -32768;
    repeat (3) step(0, 1, s);

    tag = "R6";
    void'($urandom(7));
    for (int n = 0; n < 150; n++) begin
      int span;
      span = (n % 2 == 1) ? 65536 : 4096;
      for (int i = 0; i < 8; i++) s[i] = int'($urandom % span) - span / 2;
      step(0, ($urandom % 4) != 0, s);
    end

    tag = "R8";
    step(1, 0, z);
    for (int i = 0; i < 8; i++) s[i] = 5000 - 1100 * i;
    repeat (3) step(0, 1, s);

    repeat (3) step(0, 0, z);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule